// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block drives the control-register port of a serial PHY, where every transfer is a four-phase handshake between a strobe and a single acknowledge line. A host presents one command at a time: load a register address into the PHY, write a 16-bit value to the addressed register, or read it back. The master puts the value on the PHY's 16-bit input bus, then steps the matching strobes up and down, waiting for the acknowledge to follow each edge. At the end it reports completion, a timeout flag and, for reads, the captured data.

Each acknowledge wait samples the line at most ten times, with a fixed gap of `POLL_GAP_CYC` clock cycles between samples. If the expected level never appears, the master drops every strobe and finishes with an error. A write whose value has bit 0 set is a PHY reset request. A PHY in reset cannot answer, so the master raises the write strobe after the data capture, leaves it high and finishes without waiting. A power-down test output is carried alongside the strobes and is unaffected by them.

Top module: `phy_ctl_master`

## Requirements
- R1: Command code 0 (address) puts `cmd_data` on `phy_din`. It raises `phy_cap_addr` and waits for `phy_ack` high, then lowers the strobe and waits for `phy_ack` low. The PHY then holds that value as its current address.
- R2: Command code 1 (write) puts `cmd_data` on `phy_din` and runs the raise/ack-high/lower/ack-low handshake on `phy_cap_data`. It then runs the same handshake on `phy_wr`, and the PHY's addressed register takes the value.
- R3: Command code 2 (read) raises `phy_rd` and waits for `phy_ack` high. At that poll it latches `phy_dout` into `rd_data`, then lowers `phy_rd` and waits for `phy_ack` low.
- R4: Each acknowledge wait samples `phy_ack` first in the cycle after the strobe changes, then every `POLL_GAP_CYC` cycles, for at most `MAX_POLLS` (10) samples. If all of them fail, `done` and `err` are asserted together. For a dead acknowledge on an address command, this happens 1+9*`POLL_GAP_CYC` cycles after the command is accepted.
- R5: On a timeout, all four strobes are low and `busy` is low in the cycle `done` is reported.
- R6: A write whose value has bit 0 set finishes right after the capture-data handshake, with `err` low and `phy_wr` left high. `phy_wr` stays high until the next accepted command lowers it.
- R7: `busy` is high from the cycle after acceptance until completion. A command presented while `busy` is high has no effect on the PHY bus or the outcome.
- R8: Command code 3 is ignored: the master stays idle, raises no strobe and reports no `done`.
- R9: `phy_pwrdn` follows `pwrdn_req` one cycle later, whether or not an operation is in flight.
- R10: After reset, all strobes, `busy`, `done`, `err`, `rd_data` and `phy_din` are zero.
- R11: `done` is a one-cycle pulse, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 none |
| cmd_data | input | 16 | Address or write value |
| pwrdn_req | input | 1 | Requested power-down test level |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rd_data | output | 16 | Last read value |
| phy_din | output | 16 | PHY data-in bus |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_pwrdn | output | 1 | Power-down test bit |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | 16 | PHY data-out bus |

## Verification
The hardest situation to reach is a timeout in the lowering half of a handshake. The acknowledge must rise on time and then refuse to fall, which a well-behaved PHY never does. The bench's PHY model has a stuck-high mode for this and a dead mode for a timeout in the raising half, and both counts are checked to the exact cycle. The held write strobe after a reset-bit write is observed at the pins and then through the next command. That command meets an acknowledge already high.

// File: rtl/phy_ctl_master.sv
module phy_ctl_master #(
  parameter int DW           = 16,
  parameter int POLL_GAP_CYC = 12500,
  parameter int MAX_POLLS    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic          pwrdn_req,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  output logic          phy_pwrdn,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);
  localparam int GW = $clog2(POLL_GAP_CYC + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} state_t;
  localparam logic [1:0] PH_CA = 2'd0, PH_CD = 2'd1, PH_WR = 2'd2, PH_RD = 2'd3;

  state_t      st;
  logic [1:0]  ph, ph_n;
  logic [3:0]  stb;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pcnt;
  logic        want;

  assign busy         = (st != S_IDLE);
  assign want         = (st == S_HI);
  assign phy_cap_addr = stb[PH_CA];
  assign phy_cap_data = stb[PH_CD];
  assign phy_wr       = stb[PH_WR];
  assign phy_rd       = stb[PH_RD];

  always_comb begin
    case (cmd_op)
      2'd0:    ph_n = PH_CA;
      2'd1:    ph_n = PH_CD;
      default: ph_n = PH_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_CA; stb <= '0; gcnt <= '0; pcnt <= '0;
      done <= 1'b0; err <= 1'b0; rd_data <= '0; phy_din <= '0; phy_pwrdn <= 1'b0;
    end else begin
      done      <= 1'b0;
      err       <= 1'b0;
      phy_pwrdn <= pwrdn_req;
      case (st)
        S_IDLE: if (cmd_valid && cmd_op != 2'd3) begin
          ph   <= ph_n;
          stb  <= 4'b0001 << ph_n;
          gcnt <= '0;
          pcnt <= '0;
          st   <= S_HI;
          if (cmd_op != 2'd2) phy_din <= cmd_data;
        end
        default: begin
          if (gcnt != '0) begin
            gcnt <= gcnt - 1'b1;
          end else if (phy_ack == want) begin
            pcnt <= '0;
            if (st == S_HI) begin
              stb <= '0;
              st  <= S_LO;
              if (ph == PH_RD) rd_data <= phy_dout;
            end else if (ph == PH_CD) begin
              stb <= 4'b0001 << PH_WR;
              if (phy_din[0]) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                ph <= PH_WR;
                st <= S_HI;
              end
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end else if (pcnt == PW'(MAX_POLLS - 1)) begin
            stb  <= '0;
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            pcnt <= pcnt + 1'b1;
            gcnt <= GW'(POLL_GAP_CYC - 1);
          end
        end
      endcase
    end
  end

  a_r1_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));
  a_r5_timeout_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(phy_cap_addr || phy_cap_data || phy_wr || phy_rd) && !busy);
  a_r7_din_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(phy_din));
  a_r9_pwrdn_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> phy_pwrdn == $past(pwrdn_req));
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/phy_ctl_master_tb.sv
module phy_ctl_master_tb_top;
  localparam int GAP = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, pwrdn_req = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [15:0] cmd_data = '0;
  logic busy, done, err, phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_pwrdn, phy_ack;
  logic [15:0] rd_data, phy_din, phy_dout;

  always #4 clk = ~clk;

  phy_ctl_master #(.DW(16), .POLL_GAP_CYC(GAP), .MAX_POLLS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .pwrdn_req(pwrdn_req), .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_pwrdn(phy_pwrdn), .phy_ack(phy_ack),
    .phy_dout(phy_dout));

  // PHY model
  logic [15:0] hist = '0, maddr = '0, mdata = '0;
  logic [15:0] mem [16];
  logic [3:0] prev = '0;
  int lat = 0;
  logic dead = 1'b0, stuck = 1'b0;
  wire any_stb = phy_cap_addr | phy_cap_data | phy_wr | phy_rd;
  assign phy_ack  = dead ? 1'b0 : stuck ? 1'b1 : hist[lat];
  assign phy_dout = mem[maddr[3:0]];
  initial for (int i = 0; i < 16; i++) mem[i] = '0;
  always @(posedge clk) begin
    hist <= {hist[14:0], any_stb};
    prev <= {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
    if (phy_cap_addr && !prev[0]) maddr <= phy_din;
    if (phy_cap_data && !prev[1]) mdata <= phy_din;
    if (phy_wr && !prev[2]) mem[maddr[3:0]] <= mdata;
  end

  int n_chk = 0, n_fail = 0, cyc_total = 0;
  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_total);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  int cyc;
  task automatic run_cmd(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk); cyc++;
    end
    cyc = cyc - 1;
  endtask

  // op, data, is_read, expected read value
  localparam logic [34:0] VEC [12] = '{
    {2'd0, 16'h0001, 1'b0, 16'h0000},
    {2'd1, 16'h0000, 1'b0, 16'h0000},
    {2'd2, 16'h0000, 1'b1, 16'h0000},
    {2'd1, 16'h5A5A, 1'b0, 16'h0000},
    {2'd2, 16'h0000, 1'b1, 16'h5A5A},
    {2'd1, 16'h1234, 1'b0, 16'h0000},
    {2'd2, 16'h0000, 1'b1, 16'h1234},
    {2'd0, 16'h0009, 1'b0, 16'h0000},
    {2'd1, 16'h00F4, 1'b0, 16'h0000},
    {2'd2, 16'h0000, 1'b1, 16'h00F4},
    {2'd0, 16'h0001, 1'b0, 16'h0000},
    {2'd2, 16'h0000, 1'b1, 16'h1234}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({phy_cap_addr, phy_cap_data, phy_wr, phy_rd, busy, done, err} == 7'b0 && rd_data == 0 && phy_din == 0,
        "R10 reset outputs", {busy, done, err, phy_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      lat = i % 4;
      run_cmd(VEC[i][34:33], VEC[i][32:17]);
      chk(done && !err, "R1/R2/R3 completes without error", {done, err}, 2'b10);
      if (VEC[i][34:33] == 2'd0) chk(maddr == VEC[i][32:17], "R1 address captured", maddr, VEC[i][32:17]);
      if (VEC[i][34:33] == 2'd1) chk(!phy_wr && mem[maddr[3:0]] == VEC[i][32:17], "R2 value written",
                                     mem[maddr[3:0]], VEC[i][32:17]);
      if (VEC[i][16]) chk(rd_data == VEC[i][15:0], "R3 read data", rd_data, VEC[i][15:0]);
      @(negedge clk);
      chk(!done, "R11 done single pulse", done, 0);
    end

    // R7 command while busy is ignored
    lat = 3;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h0002;
    @(negedge clk); cmd_data = 16'h0005;
    chk(busy, "R7 busy during operation", busy, 1);
    @(negedge clk); cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(maddr == 16'h0002 && phy_din == 16'h0002, "R7 busy command ignored", maddr, 16'h0002);

    // R8 code 3 ignored
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd3; cmd_data = 16'h0007;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) begin
      chk(!busy && !done && !any_stb && phy_din == 16'h0002, "R8 code 3 no effect", {busy, done, any_stb}, 0);
      @(negedge clk);
    end

    // R9 power-down independent of handshake
    lat = 2;
    @(negedge clk); pwrdn_req = 1'b1; cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk); cmd_valid = 1'b0;
    chk(phy_pwrdn && busy, "R9 pwrdn follows during op", {phy_pwrdn, busy}, 2'b11);
    while (!done) @(negedge clk);
    chk(!err && phy_pwrdn, "R9 op completes with pwrdn held", {err, phy_pwrdn}, 2'b01);
    pwrdn_req = 1'b0;
    @(negedge clk);
    chk(!phy_pwrdn, "R9 pwrdn released", phy_pwrdn, 0);

    // R4/R5 timeout in the raising half
    dead = 1'b1;
    run_cmd(2'd0, 16'h000A);
    chk(cyc == 1 + 9 * GAP, "R4 timeout cycle (ack never high)", cyc, 1 + 9 * GAP);
    chk(err && done, "R4 timeout error flagged", {done, err}, 2'b11);
    chk(!any_stb && !busy, "R5 strobes low after timeout", {any_stb, busy}, 0);
    dead = 1'b0;
    repeat (10) @(negedge clk);

    // R4/R5 timeout in the lowering half
    stuck = 1'b1;
    run_cmd(2'd2, 16'h0000);
    chk(cyc == 2 + 9 * GAP, "R4 timeout cycle (ack never low)", cyc, 2 + 9 * GAP);
    chk(err && !any_stb && !busy, "R5 lowering-half timeout", {err, any_stb, busy}, 3'b100);
    stuck = 1'b0;
    repeat (10) @(negedge clk);

    // R6 reset-bit write
    lat = 0;
    run_cmd(2'd0, 16'h0003);
    run_cmd(2'd1, 16'h0001);
    chk(!err && phy_wr, "R6 write strobe left high at done", {err, phy_wr}, 2'b01);
    @(negedge clk);
    chk(phy_wr && !busy, "R6 write strobe held while idle", {phy_wr, busy}, 2'b10);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h0001;
    @(negedge clk); cmd_valid = 1'b0;
    chk(!phy_wr && phy_cap_addr, "R6 next command drops write strobe", {phy_wr, phy_cap_addr}, 2'b01);
    while (!done) @(negedge clk);
    chk(!err && maddr == 16'h0001, "R6 command after reset write completes", maddr, 16'h0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule